// File: doc/BRIEF.md
# Dual-Bank Processor Register File

This block is the register storage of a small 16-bit processor core. It keeps two complete copies of seven general registers: four data registers, two address registers and a frame base. A bit in the flag register picks which copy is visible. Next to the banks it holds the registers that are not duplicated: a 20-bit program counter, a 20-bit interrupt table base, a user and an interrupt stack pointer, a static base and the flag word. A second flag bit picks which stack pointer answers to the generic stack-pointer index.

The core reaches the file through one write port and two independent read ports. Each port carries a 4-bit register index and a 2-bit access size. Sizes are low byte `2'b00`, high byte `2'b01`, 16-bit word `2'b10` and 32-bit pair `2'b11`. Reads are purely combinational and writes land on the rising clock edge. No data stream passes through the block, so every pin is a plain control or data pin with no valid/ready handshake: a write is taken on every edge where `wr_en` is high, and a read port never stalls.

Register index map: 0 to 3 data registers D0 to D3, 4 and 5 address registers, 6 frame base, 7 static base, 8 table base, 9 table base upper nibble, 10 selected stack pointer, 11 user stack pointer, 12 interrupt stack pointer, 13 flags, 14 program counter, 15 unused.

Top module: `cpu_regfile`

## Requirements
- R1: A synchronous reset (`rst` high at a rising edge) clears every register in both banks, the system registers and the flags. Afterwards bank 0 and the interrupt stack pointer are active and every legal read returns zero.
- R2: Flag bit 4 selects the active bank (0 or 1). Indices 0 to 6 read and write only the active bank, and a write never alters the other bank.
- R3: Byte sizes are legal only on indices 0 and 1. Size `2'b00` addresses bits 7:0 and size `2'b01` addresses bits 15:8. The write data comes from `wr_data[7:0]`, the read data is returned zero-extended in bits 7:0, and a byte write leaves the other half unchanged.
- R4: Pair size on index 0 accesses {D2,D0}, and on index 1 it accesses {D3,D1}, with the higher-numbered register in bits 31:16. A pair write updates both registers at the same edge.
- R5: Word size on indices 0 to 7 writes `wr_data[15:0]` and reads the register zero-extended to 32 bits.
- R6: The program counter (index 14) is reachable only with pair size and holds 20 bits from `wr_data[19:0]`. On index 8, pair size accesses the whole 20-bit table base and word size writes only its low 16 bits. Index 9 with word size accesses the upper 4 bits through data bits 3:0.
- R7: Index 10 goes to the user stack pointer when flag bit 7 is 1 and to the interrupt stack pointer when it is 0. Indices 11 and 12 reach the user and the interrupt pointer directly.
- R8: The flag word (index 13, word size) stores bits 7:0 and a priority level in bits 14:12. Bits 15 and 11:8 read as zero and ignore writes.
- R9: Any index and size combination not listed in R3 to R8 is illegal. An illegal write changes no state, and an illegal read returns zero.
- R10: Writes take effect at the rising edge. A read in the same cycle as a write to that register returns the old value, with no bypass.
- R11: A flag write that changes the bank select moves indices 0 to 6 to the new bank from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Write strobe |
| wr_sel | input | 4 | Write register index |
| wr_size | input | 2 | Write access size |
| wr_data | input | 32 | Write data |
| rd_a_sel | input | 4 | Read port A register index |
| rd_a_size | input | 2 | Read port A access size |
| rd_a_data | output | 32 | Read port A data |
| rd_b_sel | input | 4 | Read port B register index |
| rd_b_size | input | 2 | Read port B access size |
| rd_b_data | output | 32 | Read port B data |

## Verification
The hardest case to reach is a bank switch at a moment when both banks hold distinct, non-zero contents. The stack-pointer select must also flip at points where a byte, pair or stack write follows. The bench writes pseudo-random words into the flag register as part of a sweep over every index and size. This flips both select bits many times while the other registers fill with changing data. After every write, all 64 index and size combinations are read on both ports and compared with a model kept in the bench.

// File: rtl/rf_pkg.sv
package rf_pkg;
  localparam int WORD_W = 16;
  localparam int ADDR_W = 20;
  localparam int NBANK  = 2;
  localparam int NBREG  = 7;
  localparam int SEL_W  = 4;
  localparam int PORT_W = 2 * WORD_W;

  typedef enum logic [1:0] {
    SZ_LO   = 2'b00,
    SZ_HI   = 2'b01,
    SZ_WORD = 2'b10,
    SZ_PAIR = 2'b11
  } size_e;

  localparam logic [SEL_W-1:0] IX_SB   = 4'd7;
  localparam logic [SEL_W-1:0] IX_TBL  = 4'd8;
  localparam logic [SEL_W-1:0] IX_TBLH = 4'd9;
  localparam logic [SEL_W-1:0] IX_SP   = 4'd10;
  localparam logic [SEL_W-1:0] IX_USP  = 4'd11;
  localparam logic [SEL_W-1:0] IX_ISP  = 4'd12;
  localparam logic [SEL_W-1:0] IX_FLG  = 4'd13;
  localparam logic [SEL_W-1:0] IX_PC   = 4'd14;

  localparam int FB_BANK = 4;
  localparam int FB_STK  = 7;
  localparam logic [WORD_W-1:0] FLG_MASK = 16'h70FF;

  function automatic logic access_ok(logic [SEL_W-1:0] sel, size_e sz);
    case (sz)
      SZ_LO, SZ_HI: access_ok = (sel < 4'd2);
      SZ_WORD:      access_ok = (sel <= IX_FLG);
      default:      access_ok = (sel == 4'd0) || (sel == 4'd1) ||
                                (sel == IX_TBL) || (sel == IX_PC);
    endcase
  endfunction
endpackage

// File: rtl/rf_bank.sv
module rf_bank
  import rf_pkg::*;
#(
  parameter int W = 16,
  parameter int N = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [SEL_W-1:0] sel,
  input  size_e            sz,
  input  logic [2*W-1:0]   wd,
  output logic [N*W-1:0]   regs_flat
);
  localparam int HW = W / 2;

  logic [W-1:0] r [N];

  for (genvar i = 0; i < N; i++) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst) begin
        r[i] <= '0;
      end else if (we) begin
        if (int'(sel) == i) begin
          case (sz)
            SZ_LO:   r[i][HW-1:0] <= wd[HW-1:0];
            SZ_HI:   r[i][W-1:HW] <= wd[HW-1:0];
            default: r[i]         <= wd[W-1:0];
          endcase
        end else if (sz == SZ_PAIR && int'(sel) + 2 == i) begin
          r[i] <= wd[2*W-1:W];
        end
      end
    end
    assign regs_flat[i*W +: W] = r[i];
  end
endmodule

// File: rtl/rf_sysregs.sv
module rf_sysregs
  import rf_pkg::*;
#(
  parameter int W  = 16,
  parameter int AW = 20
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [SEL_W-1:0] sel,
  input  size_e            sz,
  input  logic [AW-1:0]    wd,
  output logic [AW-1:0]    pc,
  output logic [AW-1:0]    tbl,
  output logic [W-1:0]     usp,
  output logic [W-1:0]     isp,
  output logic [W-1:0]     sb,
  output logic [W-1:0]     flg
);
  localparam int TH = AW - W;

  always_ff @(posedge clk) begin
    if (rst) begin
      pc  <= '0;
      tbl <= '0;
      usp <= '0;
      isp <= '0;
      sb  <= '0;
      flg <= '0;
    end else if (we) begin
      case (sel)
        IX_SB:   sb <= wd[W-1:0];
        IX_TBL:  if (sz == SZ_PAIR) tbl <= wd;
                 else tbl[W-1:0] <= wd[W-1:0];
        IX_TBLH: tbl[AW-1:W] <= wd[TH-1:0];
        IX_SP:   if (flg[FB_STK]) usp <= wd[W-1:0];
                 else isp <= wd[W-1:0];
        IX_USP:  usp <= wd[W-1:0];
        IX_ISP:  isp <= wd[W-1:0];
        IX_FLG:  flg <= wd[W-1:0] & FLG_MASK;
        IX_PC:   pc  <= wd;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/rf_rdport.sv
module rf_rdport
  import rf_pkg::*;
#(
  parameter int W  = 16,
  parameter int AW = 20,
  parameter int N  = 7
) (
  input  logic [SEL_W-1:0] sel,
  input  size_e            sz,
  input  logic [N*W-1:0]   bank_flat,
  input  logic [AW-1:0]    pc,
  input  logic [AW-1:0]    tbl,
  input  logic [W-1:0]     usp,
  input  logic [W-1:0]     isp,
  input  logic [W-1:0]     sb,
  input  logic [W-1:0]     flg,
  output logic [2*W-1:0]   data
);
  localparam int HW = W / 2;
  localparam int TH = AW - W;

  logic [W-1:0] lo_w;
  logic [W-1:0] hi_w;

  always_comb begin
    lo_w = '0;
    hi_w = '0;
    data = '0;
    if (int'(sel) < N) lo_w = bank_flat[int'(sel)*W +: W];
    if (sel < 4'd2)    hi_w = bank_flat[(int'(sel)+2)*W +: W];
    if (access_ok(sel, sz)) begin
      if (int'(sel) < N) begin
        case (sz)
          SZ_LO:   data[HW-1:0] = lo_w[HW-1:0];
          SZ_HI:   data[HW-1:0] = lo_w[W-1:HW];
          SZ_WORD: data[W-1:0]  = lo_w;
          default: data         = {hi_w, lo_w};
        endcase
      end else begin
        case (sel)
          IX_SB:   data[W-1:0]  = sb;
          IX_TBL:  if (sz == SZ_PAIR) data[AW-1:0] = tbl;
                   else data[W-1:0] = tbl[W-1:0];
          IX_TBLH: data[TH-1:0] = tbl[AW-1:W];
          IX_SP:   data[W-1:0]  = flg[FB_STK] ? usp : isp;
          IX_USP:  data[W-1:0]  = usp;
          IX_ISP:  data[W-1:0]  = isp;
          IX_FLG:  data[W-1:0]  = flg;
          IX_PC:   data[AW-1:0] = pc;
          default: data = '0;
        endcase
      end
    end
  end
endmodule

// File: rtl/cpu_regfile.sv
module cpu_regfile
  import rf_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [SEL_W-1:0]  wr_sel,
  input  logic [1:0]        wr_size,
  input  logic [PORT_W-1:0] wr_data,
  input  logic [SEL_W-1:0]  rd_a_sel,
  input  logic [1:0]        rd_a_size,
  output logic [PORT_W-1:0] rd_a_data,
  input  logic [SEL_W-1:0]  rd_b_sel,
  input  logic [1:0]        rd_b_size,
  output logic [PORT_W-1:0] rd_b_data
);
  localparam int BANK_BITS = NBREG * WORD_W;

  logic                 wr_ok;
  logic                 bsel;
  logic [BANK_BITS-1:0] bank_flat [NBANK];
  logic [BANK_BITS-1:0] act_flat;
  logic [ADDR_W-1:0]    pc_q, tbl_q;
  logic [WORD_W-1:0]    usp_q, isp_q, sb_q, flg_q;

  assign wr_ok    = wr_en && access_ok(wr_sel, size_e'(wr_size));
  assign bsel     = flg_q[FB_BANK];
  assign act_flat = bank_flat[bsel];

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    logic bank_we;
    assign bank_we = wr_ok && (int'(wr_sel) < NBREG) && (int'(bsel) == b);
    rf_bank #(.W(WORD_W), .N(NBREG)) u_bank (
      .clk(clk), .rst(rst), .we(bank_we), .sel(wr_sel),
      .sz(size_e'(wr_size)), .wd(wr_data), .regs_flat(bank_flat[b])
    );
  end

  rf_sysregs #(.W(WORD_W), .AW(ADDR_W)) u_sys (
    .clk(clk), .rst(rst), .we(wr_ok), .sel(wr_sel),
    .sz(size_e'(wr_size)), .wd(wr_data[ADDR_W-1:0]),
    .pc(pc_q), .tbl(tbl_q), .usp(usp_q), .isp(isp_q), .sb(sb_q), .flg(flg_q)
  );

  rf_rdport #(.W(WORD_W), .AW(ADDR_W), .N(NBREG)) u_rd_a (
    .sel(rd_a_sel), .sz(size_e'(rd_a_size)), .bank_flat(act_flat),
    .pc(pc_q), .tbl(tbl_q), .usp(usp_q), .isp(isp_q), .sb(sb_q), .flg(flg_q),
    .data(rd_a_data)
  );

  rf_rdport #(.W(WORD_W), .AW(ADDR_W), .N(NBREG)) u_rd_b (
    .sel(rd_b_sel), .sz(size_e'(rd_b_size)), .bank_flat(act_flat),
    .pc(pc_q), .tbl(tbl_q), .usp(usp_q), .isp(isp_q), .sb(sb_q), .flg(flg_q),
    .data(rd_b_data)
  );
endmodule

// File: rtl/cpu_regfile_chk.sv
module cpu_regfile_chk
  import rf_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic              wr_en,
  input logic [SEL_W-1:0]  wr_sel,
  input logic [1:0]        wr_size,
  input logic [PORT_W-1:0] wr_data,
  input logic [NBREG*WORD_W-1:0] bank0,
  input logic [NBREG*WORD_W-1:0] bank1,
  input logic [ADDR_W-1:0] pc,
  input logic [ADDR_W-1:0] tbl,
  input logic [WORD_W-1:0] usp,
  input logic [WORD_W-1:0] isp,
  input logic [WORD_W-1:0] sb,
  input logic [WORD_W-1:0] flg
);
  logic illegal_wr;
  assign illegal_wr = wr_en && !access_ok(wr_sel, size_e'(wr_size));

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    $past(rst) |-> (bank0 == '0 && bank1 == '0 && pc == '0 && tbl == '0 &&
                    usp == '0 && isp == '0 && sb == '0 && flg == '0));

  // R2
  idle_bank1_chk: assert property (@(posedge clk) disable iff (rst)
    !flg[FB_BANK] |=> $stable(bank1));

  // R2
  idle_bank0_chk: assert property (@(posedge clk) disable iff (rst)
    flg[FB_BANK] |=> $stable(bank0));

  // R3
  byte_keep_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_sel == 4'd0 && wr_size == 2'b00 && !flg[FB_BANK])
    |=> (bank0[15:8] == $past(bank0[15:8]) && bank0[7:0] == $past(wr_data[7:0])));

  // R4
  pair_write_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_sel == 4'd1 && wr_size == 2'b11 && !flg[FB_BANK])
    |=> (bank0[31:16] == $past(wr_data[15:0]) && bank0[63:48] == $past(wr_data[31:16])));

  // R7
  user_sp_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_sel == IX_SP && wr_size == 2'b10 && flg[FB_STK])
    |=> (usp == $past(wr_data[15:0]) && $stable(isp)));

  // R8
  flag_mask_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_sel == IX_FLG && wr_size == 2'b10)
    |=> (flg == ($past(wr_data[15:0]) & 16'h70FF)));

  // R9
  illegal_ignore_chk: assert property (@(posedge clk) disable iff (rst)
    illegal_wr |=> ($stable(bank0) && $stable(bank1) && $stable(pc) && $stable(tbl) &&
                    $stable(usp) && $stable(isp) && $stable(sb) && $stable(flg)));
endmodule

bind cpu_regfile cpu_regfile_chk u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_size(wr_size),
  .wr_data(wr_data), .bank0(bank_flat[0]), .bank1(bank_flat[1]),
  .pc(pc_q), .tbl(tbl_q), .usp(usp_q), .isp(isp_q), .sb(sb_q), .flg(flg_q)
);

// File: tb/cpu_regfile_bench.sv
`timescale 1ns/1ps
module cpu_regfile_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [3:0]  wr_sel = '0;
  logic [1:0]  wr_size = '0;
  logic [31:0] wr_data = '0;
  logic [3:0]  rd_a_sel = '0, rd_b_sel = '0;
  logic [1:0]  rd_a_size = '0, rd_b_size = '0;
  logic [31:0] rd_a_data, rd_b_data;

  int nchk = 0;
  int nerr = 0;

  always #2.5 clk = ~clk;

  cpu_regfile u_cpu_regfile (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_size(wr_size),
    .wr_data(wr_data), .rd_a_sel(rd_a_sel), .rd_a_size(rd_a_size),
    .rd_a_data(rd_a_data), .rd_b_sel(rd_b_sel), .rd_b_size(rd_b_size),
    .rd_b_data(rd_b_data)
  );

  // Bench model of the register state
  logic [15:0] mb [2][7];
  logic [19:0] mpc, mtbl;
  logic [15:0] musp, misp, msb, mflg;

  function automatic bit m_ok(int sel, int sz);
    if (sz < 2)  return sel < 2;
    if (sz == 2) return sel <= 13;
    return sel == 0 || sel == 1 || sel == 8 || sel == 14;
  endfunction

  function automatic logic [31:0] m_rd(int sel, int sz);
    int bk;
    logic [15:0] w;
    bk = int'(mflg[4]);
    if (!m_ok(sel, sz)) return 32'd0;
    if (sel < 7) begin
      w = mb[bk][sel];
      case (sz)
        0: return {24'd0, w[7:0]};
        1: return {24'd0, w[15:8]};
        2: return {16'd0, w};
        default: return {mb[bk][sel+2], w};
      endcase
    end
    case (sel)
      7:  return {16'd0, msb};
      8:  return (sz == 3) ? {12'd0, mtbl} : {16'd0, mtbl[15:0]};
      9:  return {28'd0, mtbl[19:16]};
      10: return {16'd0, mflg[7] ? musp : misp};
      11: return {16'd0, musp};
      12: return {16'd0, misp};
      13: return {16'd0, mflg};
      default: return {12'd0, mpc};
    endcase
  endfunction

  task automatic m_wr(int sel, int sz, logic [31:0] d);
    int bk;
    bk = int'(mflg[4]);
    if (!m_ok(sel, sz)) return;
    if (sel < 7) begin
      case (sz)
        0: mb[bk][sel][7:0]  = d[7:0];
        1: mb[bk][sel][15:8] = d[7:0];
        2: mb[bk][sel]       = d[15:0];
        default: begin mb[bk][sel] = d[15:0]; mb[bk][sel+2] = d[31:16]; end
      endcase
    end else begin
      case (sel)
        7:  msb = d[15:0];
        8:  if (sz == 3) mtbl = d[19:0]; else mtbl[15:0] = d[15:0];
        9:  mtbl[19:16] = d[3:0];
        10: if (mflg[7]) musp = d[15:0]; else misp = d[15:0];
        11: musp = d[15:0];
        12: misp = d[15:0];
        13: mflg = d[15:0] & 16'h70FF;
        default: mpc = d[19:0];
      endcase
    end
  endtask

  task automatic m_clear();
    for (int b = 0; b < 2; b++)
      for (int i = 0; i < 7; i++) mb[b][i] = '0;
    mpc = '0; mtbl = '0; musp = '0; misp = '0; msb = '0; mflg = '0;
  endtask

  function automatic string tag(int sel, int sz);
    if (!m_ok(sel, sz)) return "R9";
    if (sel < 2 && sz < 2) return "R3";
    if (sel < 2 && sz == 3) return "R4";
    if (sel <= 7) return "R5";
    if (sel == 8 || sel == 9 || sel == 14) return "R6";
    if (sel >= 10 && sel <= 12) return "R7";
    return "R8";
  endfunction

  task automatic chk(string rq, string what, logic [31:0] act, logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s %s actual=%h expected=%h", rq, what, act, exp);
    end
  endtask

  task automatic sweep_reads(string rq_override);
    for (int s = 0; s < 16; s++) begin
      for (int z = 0; z < 4; z++) begin
        rd_a_sel = 4'(s); rd_a_size = 2'(z);
        rd_b_sel = 4'(15 - s); rd_b_size = 2'(3 - z);
        #0.2;
        chk((rq_override != "") ? rq_override : tag(s, z),
            $sformatf("port A sel=%0d size=%0d", s, z), rd_a_data, m_rd(s, z));
        chk((rq_override != "") ? rq_override : tag(15 - s, 3 - z),
            $sformatf("port B sel=%0d size=%0d", 15 - s, 3 - z), rd_b_data, m_rd(15 - s, 3 - z));
      end
    end
  endtask

  task automatic do_wr(int sel, int sz, logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = 4'(sel); wr_size = 2'(sz); wr_data = d;
    rd_a_sel = 4'(sel); rd_a_size = 2'(sz);
    #0.5;
    // R10: old value visible until the edge
    chk("R10", $sformatf("pre-edge read sel=%0d size=%0d", sel, sz), rd_a_data, m_rd(sel, sz));
    @(posedge clk);
    m_wr(sel, sz, d);
    #0.5;
    wr_en = 1'b0;
  endtask

  task automatic rd_one(string rq, int sel, int sz, logic [31:0] exp);
    @(negedge clk);
    rd_a_sel = 4'(sel); rd_a_size = 2'(sz);
    #0.5;
    chk(rq, $sformatf("sel=%0d size=%0d", sel, sz), rd_a_data, exp);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nerr++; nchk++;
    $display("FAIL watchdog run did not complete");
    $display("CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end

  initial begin
    logic [31:0] seed;
    seed = 32'h1234_5678;
    m_clear();
    // load junk during reset: must be cleared
    @(negedge clk);
    wr_en = 1'b1; wr_sel = 4'd0; wr_size = 2'b10; wr_data = 32'hFFFF_FFFF;
    repeat (3) @(posedge clk);
    #0.5; rst = 1'b0; wr_en = 1'b0;
    @(negedge clk);
    // R1: everything reads zero after reset
    sweep_reads("R1");
    // R1/R7: interrupt pointer active after reset
    do_wr(10, 2, 32'h0000_ABCD);
    rd_one("R1", 12, 2, 32'h0000_ABCD);
    rd_one("R7", 11, 2, 32'h0);

    // R2/R11: bank switch
    do_wr(0, 2, 32'h0000_1111);
    do_wr(13, 2, 32'h0000_0010);
    rd_one("R11", 0, 2, 32'h0);
    do_wr(0, 2, 32'h0000_2222);
    rd_one("R2", 0, 2, 32'h0000_2222);
    do_wr(13, 2, 32'h0000_0000);
    rd_one("R2", 0, 2, 32'h0000_1111);

    // R3: byte halves independent
    do_wr(1, 2, 32'h0000_A5C3);
    do_wr(1, 0, 32'h0000_0077);
    rd_one("R3", 1, 2, 32'h0000_A577);
    do_wr(1, 1, 32'h0000_0099);
    rd_one("R3", 1, 2, 32'h0000_9977);

    // R4: pair write
    do_wr(0, 3, 32'hDEAD_BEEF);
    rd_one("R4", 2, 2, 32'h0000_DEAD);
    rd_one("R4", 0, 2, 32'h0000_BEEF);

    // R6: table base halves, pc only as pair
    do_wr(8, 3, 32'hFFFA_BCDE);
    rd_one("R6", 8, 3, 32'h000A_BCDE);
    do_wr(9, 2, 32'h0000_0003);
    rd_one("R6", 8, 3, 32'h0003_BCDE);
    do_wr(14, 2, 32'h0000_5555);
    rd_one("R6", 14, 3, 32'h0);
    do_wr(14, 3, 32'h1234_5678);
    rd_one("R6", 14, 3, 32'h0004_5678);

    // R8: reserved flag bits
    do_wr(13, 2, 32'h0000_FFFF);
    rd_one("R8", 13, 2, 32'h0000_70FF);
    // R7: user pointer now selected
    do_wr(10, 2, 32'h0000_4321);
    rd_one("R7", 11, 2, 32'h0000_4321);
    rd_one("R7", 12, 2, 32'h0000_ABCD);

    // R9: illegal combos change nothing
    do_wr(4, 0, 32'h0000_00AA);
    do_wr(15, 2, 32'h0000_BBBB);
    do_wr(5, 3, 32'hCCCC_CCCC);
    sweep_reads("R9");

    // Full sweep over index and size with pseudo-random data
    for (int it = 0; it < 3; it++) begin
      for (int s = 0; s < 16; s++) begin
        for (int z = 0; z < 4; z++) begin
          seed = seed * 32'd1664525 + 32'd1013904223;
          do_wr(s, z, seed);
          sweep_reads("");
        end
      end
    end

    $display("CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end
endmodule